// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A single-port synchronous memory in which a write's data word arrives one rising clock edge after its address and controls. The address, an active-low select, an active-low write strobe and one active-low enable per byte lane are captured on a rising edge. A selected read presents its word in the same clock cycle. The write data for a captured write is sampled on the next rising edge into a one-entry buffer, and the buffer is committed to the storage array on the edge after that.

Because a write's bytes can sit in the buffer, or be on the data input pins, while a read of the same word is issued, an address comparator merges the newest bytes into the read result lane by lane. The word is therefore always coherent, whether the write touched some lanes or all of them. Output drive is modelled as a separate data-out port plus a drive flag. The flag is cleared by a registered deselect or write, is raised by a selected read only after the falling clock edge, is gated at once by an asynchronous active-low output enable, and is forced low by a sleep input. While the sleep input is high, all other inputs are ignored.

Top module: `latewrite_sram`

## Requirements
- R1: While and directly after synchronous reset, `drive_o` is low. No write is pending after reset.
- R2: A read is captured at a rising edge when `cs_n_i`=0, `we_n_i`=1 and `sleep_i`=0. `drive_o` rises only after the following falling edge, if `oe_n_i`=0, and `rdata_o` then holds the addressed word. If the next capture is also a read, drive stays high across that rising edge.
- R3: A write is captured when `cs_n_i`=0, `we_n_i`=0 and `sleep_i`=0. The value on `wdata_i` at the next rising edge is stored at the captured address in every lane whose `lane_n_i` bit was 0 at capture. Lane i is bits [9i+8:9i].
- R4: `lane_n_i` has no effect on reads. The full word is returned for every lane-enable pattern.
- R5: A write captured with `lane_n_i`=4'b1111 changes no stored byte, and `drive_o` is low in that cycle.
- R6: A read of an address whose write data arrives at the same edge, or is still buffered, returns the newest bytes in the written lanes and the older contents in the other lanes.
- R7: A capture with `cs_n_i`=1 or `we_n_i`=0 makes `drive_o` low from that rising edge, in the same cycle.
- R8: `oe_n_i`=1 forces `drive_o` low at once. Returning it to 0 in a read cycle after the falling edge restores drive without a clock edge.
- R9: While `sleep_i`=1, `drive_o` is low and a read or write capture is ignored. A pending write whose data edge occurs during sleep is dropped.
- R10: When two consecutive writes hit the same address, the second overrides the first only in the lanes it enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands and write data are taken on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep: all other inputs ignored, outputs undriven |
| cs_n_i | input | 1 | Active-low select, registered |
| we_n_i | input | 1 | Active-low write strobe, registered |
| lane_n_i | input | LANES | Active-low per-lane write enables, registered |
| addr_i | input | ADDR_W | Word address, registered |
| wdata_i | input | LANES*LANE_W | Write data, sampled one edge after its address |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| rdata_o | output | LANES*LANE_W | Read data (valid while drive_o is high) |
| drive_o | output | 1 | High when the data bus would be driven |

## Verification
Two functions share a single clock edge: the buffered write commits to the array, and a read of the same word is captured while a newer write's data lands on `wdata_i`. The read must then combine the bytes on the bus, the bytes in the buffer and the older array word, each in its own lanes. This is provoked by confining random traffic to sixteen words, mixing partial-lane writes back to back with reads, and by directed write-write-read and write-read-read sequences. Every read is judged against a bench array that applies each write, lane by lane, at its data edge. Drive timing is checked twice per cycle, before and after the falling edge.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  // where a read lane takes its bytes from
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_BUF   = 2'd1,
    SRC_BUS   = 2'd2
  } src_e;

  // the bus data is newer than the buffered entry
  function automatic src_e pick_src(input logic bus_hit, input logic buf_hit);
    if (bus_hit)      return SRC_BUS;
    else if (buf_hit) return SRC_BUF;
    else              return SRC_ARRAY;
  endfunction

endpackage

// File: rtl/lwsram_ctl.sv
module lwsram_ctl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic [LANES-1:0]  lane_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_n_i,
  output logic              cmd_wr,
  output logic [LANES-1:0]  cmd_lanes,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              drive_o
);

  logic sel_now;
  logic rd_active;
  logic rd_half;

  assign sel_now = !sleep_i && !cs_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_wr    <= 1'b0;
      cmd_lanes <= '0;
      cmd_addr  <= '0;
      rd_active <= 1'b0;
    end else begin
      cmd_wr    <= sel_now && !we_n_i;
      cmd_lanes <= ~lane_n_i;
      cmd_addr  <= addr_i;
      rd_active <= sel_now && we_n_i;
    end
  end

  // second half of the read cycle: drive may start only after this edge
  always_ff @(negedge clk) begin
    if (rst) rd_half <= 1'b0;
    else     rd_half <= rd_active;
  end

  assign drive_o = rd_active && rd_half && !oe_n_i && !sleep_i;

  a_r7_quiet_after_capture: assert property (@(posedge clk) disable iff (rst)
    (sleep_i || cs_n_i || !we_n_i) |=> !drive_o);

  a_r8_oe_gates_drive: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> !drive_o);

  a_r9_sleep_undriven: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> !drive_o);

endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep_i,
  input  logic                    cmd_wr,
  input  logic [LANES-1:0]        cmd_lanes,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    cm_en,
  output logic [LANES-1:0]        cm_lanes,
  output logic [ADDR_W-1:0]       cm_addr,
  output logic [LANES*LANE_W-1:0] cm_data,
  output logic [LANES-1:0]        fwd_mask,
  output logic [LANES*LANE_W-1:0] fwd_data
);

  localparam int DW = LANES * LANE_W;

  logic              b_vld;
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_lanes;
  logic [DW-1:0]     b_data;
  logic              accept;
  logic [LANES-1:0]  hit_bus;
  logic [LANES-1:0]  hit_buf;

  // a captured write takes its data now unless sleep blocks the edge
  assign accept  = cmd_wr && !sleep_i;
  assign hit_bus = {LANES{accept && (cmd_addr == rd_addr)}} & cmd_lanes;
  assign hit_buf = {LANES{b_vld && (b_addr == rd_addr)}} & b_lanes;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_vld   <= 1'b0;
      b_addr  <= '0;
      b_lanes <= '0;
      b_data  <= '0;
    end else begin
      b_vld <= accept;
      if (accept) begin
        b_addr  <= cmd_addr;
        b_lanes <= cmd_lanes;
        b_data  <= wdata_i;
      end
    end
  end

  // the entry drains into the array on the edge after it was filled
  assign cm_en    = b_vld;
  assign cm_lanes = b_lanes;
  assign cm_addr  = b_addr;
  assign cm_data  = b_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_mask <= '0;
      fwd_data <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        case (pick_src(hit_bus[l], hit_buf[l]))
          SRC_BUS: begin
            fwd_mask[l] <= 1'b1;
            fwd_data[l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
          end
          SRC_BUF: begin
            fwd_mask[l] <= 1'b1;
            fwd_data[l*LANE_W +: LANE_W] <= b_data[l*LANE_W +: LANE_W];
          end
          default: fwd_mask[l] <= 1'b0;
        endcase
      end
    end
  end

  a_r10_single_entry: assert property (@(posedge clk) disable iff (rst)
    (b_vld && !accept) |=> !b_vld);

  a_r6_forward_has_source: assert property (@(posedge clk) disable iff (rst)
    (|fwd_mask) |-> $past(accept || b_vld));

  a_r5_empty_write_no_forward: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_lanes == '0) |=> (fwd_mask & ~$past(hit_buf)) == '0);

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        wlanes,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // one simple dual-port memory per lane, read-first
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we && wlanes[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      q <= mem[raddr];
    end

    assign rdata[l*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep_i,
  input  logic                    cs_n_i,
  input  logic                    we_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_n_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);

  localparam int DW = LANES * LANE_W;

  logic              cmd_wr;
  logic [LANES-1:0]  cmd_lanes;
  logic [ADDR_W-1:0] cmd_addr;
  logic              cm_en;
  logic [LANES-1:0]  cm_lanes;
  logic [ADDR_W-1:0] cm_addr;
  logic [DW-1:0]     cm_data;
  logic [LANES-1:0]  fwd_mask;
  logic [DW-1:0]     fwd_data;
  logic [DW-1:0]     ram_q;

  lwsram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .sleep_i   (sleep_i),
    .cs_n_i    (cs_n_i),
    .we_n_i    (we_n_i),
    .lane_n_i  (lane_n_i),
    .addr_i    (addr_i),
    .oe_n_i    (oe_n_i),
    .cmd_wr    (cmd_wr),
    .cmd_lanes (cmd_lanes),
    .cmd_addr  (cmd_addr),
    .drive_o   (drive_o)
  );

  lwsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .sleep_i   (sleep_i),
    .cmd_wr    (cmd_wr),
    .cmd_lanes (cmd_lanes),
    .cmd_addr  (cmd_addr),
    .wdata_i   (wdata_i),
    .rd_addr   (addr_i),
    .cm_en     (cm_en),
    .cm_lanes  (cm_lanes),
    .cm_addr   (cm_addr),
    .cm_data   (cm_data),
    .fwd_mask  (fwd_mask),
    .fwd_data  (fwd_data)
  );

  lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .we     (cm_en),
    .wlanes (cm_lanes),
    .waddr  (cm_addr),
    .wdata  (cm_data),
    .raddr  (addr_i),
    .rdata  (ram_q)
  );

  // per-lane merge of forwarded bytes over the array word
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign rdata_o[l*LANE_W +: LANE_W] = fwd_mask[l] ? fwd_data[l*LANE_W +: LANE_W]
                                                     : ram_q[l*LANE_W +: LANE_W];
  end

endmodule

// File: tb/test_latewrite_sram.sv
module test_latewrite_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_i = 1'b0;
  logic          cs_n_i = 1'b1;
  logic          we_n_i = 1'b1;
  logic [NL-1:0] lane_n_i = '1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          oe_n_i = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  latewrite_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_latewrite_sram (
    .clk      (clk),
    .rst      (rst),
    .sleep_i  (sleep_i),
    .cs_n_i   (cs_n_i),
    .we_n_i   (we_n_i),
    .lane_n_i (lane_n_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .oe_n_i   (oe_n_i),
    .rdata_o  (rdata_o),
    .drive_o  (drive_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic          pw_vld = 1'b0;
  logic [AW-1:0] pw_addr = '0;
  logic [NL-1:0] pw_lanes = '0;
  logic          prev_rd = 1'b0;
  logic [DW-1:0] pend_d = '0;

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return r[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: apply inputs, model the edge, check before and after the falling edge
  task automatic run(input logic c_n, input logic w_n, input logic [NL-1:0] ln,
                     input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic o_n, input logic s, input string tag);
    logic          cur_rd;
    logic          early;
    logic          late;
    logic [DW-1:0] exp;
    cs_n_i = c_n; we_n_i = w_n; lane_n_i = ln; addr_i = a;
    wdata_i = d; oe_n_i = o_n; sleep_i = s;
    @(posedge clk);
    if (pw_vld && !s)
      for (int l = 0; l < NL; l++)
        if (pw_lanes[l]) ref_mem[pw_addr][l*LW +: LW] = d[l*LW +: LW];
    pw_vld   = !s && !c_n && !w_n;
    pw_addr  = a;
    pw_lanes = ~ln;
    cur_rd   = !s && !c_n && w_n;
    exp      = ref_mem[a];
    #2;
    early = cur_rd && prev_rd && !o_n;
    chk(drive_o === early, {tag, " drive before falling edge (R2/R7)"}, {{(DW-1){1'b0}}, drive_o},
        {{(DW-1){1'b0}}, early});
    if (early) chk(rdata_o === exp, {tag, " data before falling edge"}, rdata_o, exp);
    #5;
    late = cur_rd && !o_n;
    chk(drive_o === late, {tag, " drive after falling edge (R2/R7)"}, {{(DW-1){1'b0}}, drive_o},
        {{(DW-1){1'b0}}, late});
    if (late) chk(rdata_o === exp, {tag, " read data"}, rdata_o, exp);
    prev_rd = cur_rd;
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [NL-1:0] ln,
                       input logic [DW-1:0] data, input string tag);
    run(1'b0, 1'b0, ln, a, pend_d, 1'b0, 1'b0, tag);
    pend_d = data;
  endtask

  task automatic do_rd(input logic [AW-1:0] a, input logic [NL-1:0] ln,
                       input logic o_n, input string tag);
    run(1'b0, 1'b1, ln, a, pend_d, o_n, 1'b0, tag);
    pend_d = rnd_word();
  endtask

  task automatic do_idle(input string tag);
    run(1'b1, 1'b1, 4'b0000, 8'd0, pend_d, 1'b0, 1'b0, tag);
    pend_d = rnd_word();
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int a = 0; a < (1 << AW); a++) ref_mem[a] = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(drive_o === 1'b0, "R1 drive low in reset", {{(DW-1){1'b0}}, drive_o}, '0);
    #5;
    rst = 1'b0;
    do_idle("R1");
    chk(drive_o === 1'b0, "R1 drive low after reset", {{(DW-1){1'b0}}, drive_o}, '0);

    // fill the 16-word window with full-word writes (R3)
    for (int a = 0; a < 16; a++) do_wr(a[AW-1:0], 4'b0000, rnd_word(), "R3");
    do_idle("R3");
    for (int a = 0; a < 16; a++) do_rd(a[AW-1:0], 4'b1111, 1'b0, "R3");

    // partial write then reads from bus, buffer and array (R6)
    do_wr(8'd3, 4'b1010, rnd_word(), "R6");
    do_rd(8'd3, 4'b1111, 1'b0, "R6 bus forward");
    do_rd(8'd3, 4'b1111, 1'b0, "R6 buffer forward");
    do_idle("R6");
    do_rd(8'd3, 4'b1111, 1'b0, "R6 array");

    // back-to-back writes to one word with different lanes (R10)
    do_wr(8'd5, 4'b1100, rnd_word(), "R10");
    do_wr(8'd5, 4'b0110, rnd_word(), "R10");
    do_rd(8'd5, 4'b1111, 1'b0, "R10 merge");
    do_idle("R10");
    do_rd(8'd5, 4'b0000, 1'b0, "R10 committed");

    // write with no lane enabled (R5)
    do_wr(8'd6, 4'b1111, rnd_word(), "R5");
    do_rd(8'd6, 4'b1111, 1'b0, "R5 unchanged");

    // lane enables ignored on reads (R4)
    do_rd(8'd7, 4'b0000, 1'b0, "R4");
    do_rd(8'd7, 4'b0101, 1'b0, "R4");

    // asynchronous output enable inside a read cycle (R8)
    do_rd(8'd8, 4'b1111, 1'b0, "R8");
    oe_n_i = 1'b1;
    #1;
    chk(drive_o === 1'b0, "R8 oe high gates drive", {{(DW-1){1'b0}}, drive_o}, '0);
    oe_n_i = 1'b0;
    #1;
    chk(drive_o === 1'b1, "R8 oe low restores drive", {{(DW-1){1'b0}}, drive_o},
        {{(DW-1){1'b0}}, 1'b1});

    // sleep blocks captures and drops a write whose data edge falls in sleep (R9)
    run(1'b0, 1'b0, 4'b0000, 8'd9, pend_d, 1'b0, 1'b1, "R9 write in sleep");
    run(1'b0, 1'b1, 4'b1111, 8'd9, rnd_word(), 1'b0, 1'b1, "R9 read in sleep");
    do_rd(8'd9, 4'b1111, 1'b0, "R9 word unchanged");
    do_wr(8'd10, 4'b0000, rnd_word(), "R9");
    run(1'b1, 1'b1, 4'b1111, 8'd0, pend_d, 1'b0, 1'b1, "R9 data edge in sleep");
    do_rd(8'd10, 4'b1111, 1'b0, "R9 dropped write");

    // read then write and deselect: drive falls at the capture edge (R7)
    do_rd(8'd11, 4'b1111, 1'b0, "R7");
    do_wr(8'd11, 4'b0011, rnd_word(), "R7 write quiets");
    do_rd(8'd11, 4'b1111, 1'b0, "R7");
    do_idle("R7 deselect quiets");

    // constrained random traffic over a small window (R6)
    for (int i = 0; i < 3000; i++) begin
      int unsigned k;
      logic [AW-1:0] a;
      logic [NL-1:0] ln;
      logic          o_n;
      k   = $urandom % 10;
      a   = AW'($urandom % 16);
      ln  = NL'($urandom);
      o_n = (($urandom % 8) == 0);
      if (k < 4)       do_wr(a, ln, rnd_word(), "R6 random write");
      else if (k < 8)  do_rd(a, ln, o_n, "R6 random read");
      else if (k == 8) do_idle("R6 random idle");
      else begin
        run(1'b0, 1'($urandom), ln, a, pend_d, o_n, 1'b1, "R9 random sleep");
        pend_d = rnd_word();
      end
    end
    do_idle("R6");
    for (int a = 0; a < 16; a++) do_rd(a[AW-1:0], 4'b1111, 1'b0, "R6 final sweep");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule